// File: doc/BRIEF.md
# Three-Wire Serial Control Register

This block receives a 16-bit control word over a three-wire port (chip-select, serial clock, serial data) and holds it on parallel outputs. The outputs drive the power switches, mute controls, record/playback and filter selects, a 5-bit volume code and a bias-mode flag of an analog audio front end. All three serial pins, and the standby input, are oversampled by a fast system clock through two-stage synchronisers. Edges of the serial lines are found in the system clock domain.

The block protects the register after power-up. When standby is released, an internal power-on interval runs first. The first complete frame after that interval is a dummy and is thrown away. The second frame is the first to be applied, and every good frame after it updates the register once. The same power-on sequence runs again, with a much shorter interval, when a frame takes the block out of bias mode. A ready flag shows when normal updates are accepted.

Top module: `ctl_serial_reg`

## Requirements
- R1: A frame is the span during which `cs_i` is high. Data is sampled on each rising edge of `sclk_i` inside the frame, least-significant bit first. When `cs_i` falls after exactly 16 samples and the block is in normal operation, `ctl_word_o` takes the received word.
- R2: `volume_o` shows bits 14 down to 10 of the register, with bit 10 weighted 1 and bit 14 weighted 16. Code 0 is minimum (mute) and code 31 is maximum. `bias_o` shows bit 15, where 1 means bias mode.
- R3: After `rst_n` the register holds the default 16'h03CD and `ready_o` is 0. In the default, bits 0 and 8 are 1 (mute transistor on, line mute on). Bits 2, 3, 6, 7 and 9 are 1 (these power switches are active-low, so 1 means off). Bit 1 is 0 (charge switch off). Bit 4 is 0 (playback). Bit 5 is 0 (16 kHz trap). The volume code is 0 and bit 15 is 0.
- R4: While `standby_n` is low, the register is held at its default, `ready_o` is 0, and frames are ignored.
- R5: When standby is released, a power-on interval of POR_CYCLES system clocks runs. Frames that end during this interval are ignored.
- R6: After the power-on interval, the first frame to end is a dummy and leaves the register at its default. The next 16-bit frame is applied, and `ready_o` rises with it.
- R7: A frame that ends with a bit count other than 16 is discarded and leaves the register unchanged.
- R8: In bias mode (register bit 15 = 1), a 16-bit frame with bit 15 = 0 returns the register to its default and drops `ready_o`. It then starts a power-on interval of BIAS_CYCLES clocks, followed by the same dummy-then-first-data sequence as R6.
- R9: In bias mode, a 16-bit frame with bit 15 = 1 updates the register normally.
- R10: `ready_o` is 1 only in normal operation, that is, from the first applied frame until the next standby or bias exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_n | input | 1 | Standby control, low holds the block in reset |
| cs_i | input | 1 | Chip-select; high frames a transfer |
| sclk_i | input | 1 | Serial clock; data sampled on its rising edge |
| sdat_i | input | 1 | Serial data, least-significant bit first |
| ctl_word_o | output | 16 | Parallel control register |
| volume_o | output | 5 | Volume code, register bits 14..10 |
| bias_o | output | 1 | Bias-mode flag, register bit 15 |
| ready_o | output | 1 | High when normal updates are accepted |

## Verification
The hardest case to reach is a frame that arrives while a power-on interval is still running. The same applies to the dummy and first-data steps that follow a bias exit, because each needs the block in a particular phase of its sequence. The bench shortens both intervals through parameters so that a complete serial frame fits inside each one. It then sends frames right after standby release and right after a bias-cancel frame, counts off the interval, and walks the dummy, malformed and first-data frames through in order.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int CTL_W = 16;
    localparam logic [CTL_W-1:0] CTL_DEFAULT = 16'h03CD;

    localparam int VOL_LSB  = 10;
    localparam int VOL_W    = 5;
    localparam int BIAS_BIT = 15;

    typedef enum logic [2:0] {
        SEQ_HOLD  = 3'd0,
        SEQ_PULSE = 3'd1,
        SEQ_DUMMY = 3'd2,
        SEQ_FIRST = 3'd3,
        SEQ_RUN   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            logic [STAGES-1:0] chain_d;

            always_comb begin
                chain_d = {chain_q[STAGES-2:0], d_i[b]};
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= chain_d;
            end

            assign q_o[b] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/ctl_rx.sv
module ctl_rx #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sclk_s,
    input  logic              sdat_s,
    output logic              done_o,
    output logic              ok_o,
    output logic [WORD_W-1:0] word_o
);

    localparam int CNT_W = $clog2(WORD_W + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

    typedef struct packed {
        logic              cs_prev;
        logic              clk_prev;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
    } rx_t;

    rx_t rx_d, rx_q;
    logic cs_rise, cs_fall, clk_rise;

    always_comb begin
        cs_rise  = cs_s & ~rx_q.cs_prev;
        cs_fall  = ~cs_s & rx_q.cs_prev;
        clk_rise = sclk_s & ~rx_q.clk_prev;

        rx_d          = rx_q;
        rx_d.cs_prev  = cs_s;
        rx_d.clk_prev = sclk_s;

        if (cs_rise) begin
            rx_d.cnt = '0;
        end else if (cs_s && clk_rise) begin
            rx_d.sh = {sdat_s, rx_q.sh[WORD_W-1:1]};
            if (rx_q.cnt != CNT_MAX) rx_d.cnt = rx_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign done_o = cs_fall;
    assign ok_o   = cs_fall && (rx_q.cnt == CNT_FULL);
    assign word_o = rx_q.sh;

    // R1: a new frame opens with an empty bit count
    p_frame_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_s) |=> (rx_q.cnt == '0));

endmodule

// File: rtl/ctl_seq.sv
module ctl_seq
    import ctl_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int POR_CYCLES  = 100000,
    parameter int BIAS_CYCLES = 250,
    parameter logic [WORD_W-1:0] DEF_WORD = CTL_DEFAULT[WORD_W-1:0]
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stby_s,
    input  logic              done_i,
    input  logic              ok_i,
    input  logic [WORD_W-1:0] rx_word_i,
    output logic [WORD_W-1:0] word_o,
    output logic              ready_o
);

    localparam int LONGEST = (POR_CYCLES > BIAS_CYCLES) ? POR_CYCLES : BIAS_CYCLES;
    localparam int TW      = (LONGEST > 1) ? $clog2(LONGEST + 1) : 1;
    localparam logic [TW-1:0] POR_LOAD  = TW'(POR_CYCLES - 1);
    localparam logic [TW-1:0] BIAS_LOAD = TW'(BIAS_CYCLES - 1);
    localparam int MODE_BIT = WORD_W - 1;

    typedef struct packed {
        seq_state_e        st;
        logic [TW-1:0]     tmr;
        logic [WORD_W-1:0] word;
    } seq_t;

    seq_t s_d, s_q;
    logic good_frame;
    logic bias_exit;

    always_comb begin
        good_frame = done_i && ok_i;
        bias_exit  = good_frame && s_q.word[MODE_BIT] && !rx_word_i[MODE_BIT];

        s_d = s_q;
        if (!stby_s) begin
            s_d.st   = SEQ_HOLD;
            s_d.tmr  = '0;
            s_d.word = DEF_WORD;
        end else begin
            unique case (s_q.st)
                SEQ_HOLD: begin
                    s_d.st   = SEQ_PULSE;
                    s_d.tmr  = POR_LOAD;
                    s_d.word = DEF_WORD;
                end
                SEQ_PULSE: begin
                    s_d.word = DEF_WORD;
                    if (s_q.tmr == '0) s_d.st  = SEQ_DUMMY;
                    else               s_d.tmr = s_q.tmr - 1'b1;
                end
                SEQ_DUMMY: begin
                    if (done_i) s_d.st = SEQ_FIRST;
                end
                SEQ_FIRST: begin
                    if (good_frame) begin
                        s_d.st   = SEQ_RUN;
                        s_d.word = rx_word_i;
                    end
                end
                SEQ_RUN: begin
                    if (bias_exit) begin
                        s_d.st   = SEQ_PULSE;
                        s_d.tmr  = BIAS_LOAD;
                        s_d.word = DEF_WORD;
                    end else if (good_frame) begin
                        s_d.word = rx_word_i;
                    end
                end
                default: begin
                    s_d.st   = SEQ_HOLD;
                    s_d.word = DEF_WORD;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= SEQ_HOLD;
            s_q.tmr  <= '0;
            s_q.word <= DEF_WORD;
        end else begin
            s_q <= s_d;
        end
    end

    assign word_o  = s_q.word;
    assign ready_o = (s_q.st == SEQ_RUN);

    // R4: standby forces the default word and drops ready
    p_stby_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !stby_s |=> (word_o == DEF_WORD) && !ready_o);

    // R5: during the power-on interval the register stays at default
    p_pulse_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SEQ_PULSE) |=> (word_o == DEF_WORD) && !ready_o);

    // R7: a frame with the wrong length leaves the register as it was
    p_bad_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_s && done_i && !ok_i) |=> $stable(word_o));

    // R6: ready only rises on an accepted frame
    p_ready_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(done_i && ok_i));

    // R8: leaving bias mode restores defaults and drops ready
    p_bias_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_s && ready_o && word_o[MODE_BIT] && done_i && ok_i && !rx_word_i[MODE_BIT])
        |=> (word_o == DEF_WORD) && !ready_o);

endmodule

// File: rtl/ctl_serial_reg.sv
module ctl_serial_reg
    import ctl_pkg::*;
#(
    parameter int POR_CYCLES  = 100000,
    parameter int BIAS_CYCLES = 250,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby_n,
    input  logic             cs_i,
    input  logic             sclk_i,
    input  logic             sdat_i,
    output logic [CTL_W-1:0] ctl_word_o,
    output logic [VOL_W-1:0] volume_o,
    output logic             bias_o,
    output logic             ready_o
);

    localparam int NPINS = 4;

    logic [NPINS-1:0] pins_raw, pins_s;
    logic             done, ok;
    logic [CTL_W-1:0] rx_word;

    assign pins_raw = {standby_n, sdat_i, sclk_i, cs_i};

    ctl_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_raw),
        .q_o   (pins_s)
    );

    ctl_rx #(.WORD_W(CTL_W)) i_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_s   (pins_s[0]),
        .sclk_s (pins_s[1]),
        .sdat_s (pins_s[2]),
        .done_o (done),
        .ok_o   (ok),
        .word_o (rx_word)
    );

    ctl_seq #(
        .WORD_W      (CTL_W),
        .POR_CYCLES  (POR_CYCLES),
        .BIAS_CYCLES (BIAS_CYCLES),
        .DEF_WORD    (CTL_DEFAULT)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .stby_s    (pins_s[3]),
        .done_i    (done),
        .ok_i      (ok),
        .rx_word_i (rx_word),
        .word_o    (ctl_word_o),
        .ready_o   (ready_o)
    );

    assign volume_o = ctl_word_o[VOL_LSB +: VOL_W];
    assign bias_o   = ctl_word_o[BIAS_BIT];

    // R1: in normal operation a full frame lands in the register
    p_apply_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_s[3] && ready_o && done && ok && !(bias_o && !rx_word[BIAS_BIT]))
        |=> (ctl_word_o == $past(rx_word)));

endmodule

// File: tb/test_ctl_serial_reg.sv
module test_ctl_serial_reg;

    localparam int POR  = 600;
    localparam int BIAS = 400;
    localparam logic [15:0] DEF = 16'h03CD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic standby_n = 1'b1;
    logic cs_i = 1'b0, sclk_i = 1'b0, sdat_i = 1'b0;
    logic [15:0] ctl_word_o;
    logic [4:0]  volume_o;
    logic        bias_o, ready_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ctl_serial_reg #(.POR_CYCLES(POR), .BIAS_CYCLES(BIAS)) i_ctl_serial_reg (
        .clk(clk), .rst_n(rst_n), .standby_n(standby_n),
        .cs_i(cs_i), .sclk_i(sclk_i), .sdat_i(sdat_i),
        .ctl_word_o(ctl_word_o), .volume_o(volume_o),
        .bias_o(bias_o), .ready_o(ready_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] w, input int nbits);
        cs_i = 1'b1;
        idle(4);
        for (int i = 0; i < nbits; i++) begin
            sdat_i = w[i];
            idle(4);
            sclk_i = 1'b1;
            idle(8);
            sclk_i = 1'b0;
            idle(4);
        end
        cs_i = 1'b0;
        idle(12);
    endtask

    task automatic t_reset_and_por();
        idle(2);
        check("R3 default word", ctl_word_o, DEF);
        check("R3 ready low", ready_o, 0);
        check("R2 volume default", volume_o, 0);
        rst_n = 1'b1;
        send(32'h0000_7FFF, 16);
        check("R5 frame in pulse ignored", ctl_word_o, DEF);
        idle(400);
        send(32'h0000_1234, 16);
        check("R6 dummy ignored", ctl_word_o, DEF);
        check("R6 ready low after dummy", ready_o, 0);
        send(32'h0000_00FF, 8);
        check("R7 short first frame", ctl_word_o, DEF);
        check("R10 still not ready", ready_o, 0);
        send(32'h0000_5A3C, 16);
        check("R6 first data applied", ctl_word_o, 16'h5A3C);
        check("R10 ready high", ready_o, 1);
        check("R2 volume field", volume_o, 22);
        check("R2 bias clear", bias_o, 0);
    endtask

    task automatic t_normal();
        send(32'h0000_7C00, 16);
        check("R2 volume max", volume_o, 31);
        check("R1 word 7C00", ctl_word_o, 16'h7C00);
        send(32'h0000_0001, 16);
        check("R1 lsb first", ctl_word_o, 16'h0001);
        check("R2 volume min", volume_o, 0);
        send(32'h0000_2A55, 16);
        check("R1 word 2A55", ctl_word_o, 16'h2A55);
    endtask

    task automatic t_bad_len();
        send(32'h0001_FFFF, 17);
        check("R7 long frame dropped", ctl_word_o, 16'h2A55);
        send(32'h0000_7FFF, 15);
        check("R7 short frame dropped", ctl_word_o, 16'h2A55);
    endtask

    task automatic t_bias();
        send(32'h0000_8123, 16);
        check("R2 bias set", bias_o, 1);
        check("R9 bias word", ctl_word_o, 16'h8123);
        send(32'h0000_9000, 16);
        check("R9 update in bias", ctl_word_o, 16'h9000);
        check("R10 ready in bias", ready_o, 1);
        send(32'h0000_0456, 16);
        check("R8 exit default", ctl_word_o, DEF);
        check("R8 exit ready low", ready_o, 0);
        send(32'h0000_0111, 16);
        check("R8 frame in short pulse", ctl_word_o, DEF);
        idle(200);
        send(32'h0000_0222, 16);
        check("R8 dummy after exit", ctl_word_o, DEF);
        check("R8 ready low after dummy", ready_o, 0);
        send(32'h0000_0777, 16);
        check("R8 first data after exit", ctl_word_o, 16'h0777);
        check("R8 ready back", ready_o, 1);
    endtask

    task automatic t_standby();
        standby_n = 1'b0;
        idle(8);
        check("R4 standby default", ctl_word_o, DEF);
        check("R4 standby ready low", ready_o, 0);
        send(32'h0000_1111, 16);
        check("R4 frame in standby", ctl_word_o, DEF);
        standby_n = 1'b1;
        idle(700);
        send(32'h0000_4444, 16);
        check("R6 dummy after standby", ctl_word_o, DEF);
        send(32'h0000_3333, 16);
        check("R6 data after standby", ctl_word_o, 16'h3333);
        check("R10 ready after standby", ready_o, 1);
    endtask

    initial begin
        idle(5);
        t_reset_and_por();
        t_normal();
        t_bad_len();
        t_bias();
        t_standby();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule